// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the hardwired control unit of a small accumulator machine. A 2-bit cycle code records which part of the instruction cycle the machine is in: fetch, indirect, execute or interrupt. A step counter records the time step within that part. In every clock cycle the block decodes the cycle code, the step and the current opcode into a vector of register-transfer strobes. The surrounding datapath and memory act on those strobes.

The datapath returns an opcode, the indirect-addressing bit, a zero flag for the incremented memory word, an interrupt request and an interrupt enable. Three opcodes have schedules: add-to-register, increment-and-skip-if-zero, and branch-and-save-return-address. Any other opcode spends one idle execute step. Interrupts are tested only when an execute part ends.

Top module: `ctl_sequencer`

## Requirements
- R1: A synchronous active-high `rst` puts the block in fetch (cycle code 00) at step 0. In the cycle after reset is released, `ctl` equals only bit 0 (PC to MAR).
- R2: The cycle code is 00 fetch, 01 indirect, 10 execute, 11 interrupt. `step` counts the time steps of the current part from 0 and returns to 0 on every change of part.
- R3: Fetch lasts three steps. Strobe bit positions are 0 PC→MAR, 1 memory→MBR, 2 MBR→IR and 3 PC+1. Step 0 asserts bit 0. Step 1 asserts bits 1 and 3. Step 2 asserts bit 2.
- R4: `ind_bit` is sampled in fetch step 2, the step in which IR is loaded. When it is 1 the next part is indirect, otherwise execute.
- R5: Indirect lasts three steps and is always followed by execute. Bit 4 is IR-address→MAR and bit 10 is MBR-address→IR-address. Step 0 asserts bit 4, step 1 asserts bit 1 and step 2 asserts bit 10.
- R6: Opcode 1 (add) executes in three steps. Bit 6 is R1←R1+MBR. Step 0 asserts bit 4, step 1 asserts bit 1 and step 2 asserts bit 6.
- R7: Opcode 2 (increment and skip) executes in four steps. Bit 11 is MBR+1 and bit 5 is MBR→memory. The steps assert, in order, bit 4, then bit 1, then bit 11, then bit 5. In step 3 bit 3 is also asserted when `zero_flag` is 1. Step 3 is reached only with this opcode.
- R8: Opcode 3 (branch and save) executes in three steps. Bit 7 is PC→MBR and bit 12 is IR-address→PC. Step 0 asserts bits 4 and 7. Step 1 asserts bits 12 and 5. Step 2 asserts bit 3.
- R9: Any other opcode executes in a single step with `ctl` all zero.
- R10: When execute ends, the next part is interrupt when `irq` and `irq_en` are both 1, and fetch otherwise.
- R11: Interrupt lasts three steps and is followed by fetch. Bit 8 is save-address→MAR and bit 9 is routine-address→PC. Step 0 asserts bit 7. Step 1 asserts bits 8 and 9. Step 2 asserts bit 5.
- R12: No step both loads MBR from memory and reads MBR into IR, into memory, into the IR address field or into the incrementer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W | Opcode field of the instruction register |
| ind_bit | input | 1 | Indirect-addressing bit of the instruction being loaded |
| zero_flag | input | 1 | High when the incremented MBR value is zero |
| irq | input | 1 | Interrupt request pending |
| irq_en | input | 1 | Interrupt enable |
| cycle_code | output | 2 | Current instruction-cycle part |
| step | output | STEP_W | Time step within the current part |
| ctl | output | STROBE_W | Register-transfer strobes for this cycle |

## Verification
Each opcode is run once with direct and once with indirect addressing, which separates the fetch branch from the execute schedules. The increment-and-skip opcode is run with the zero flag both low and high to show the skip is conditional. Interrupt requests are tried enabled, disabled and absent, after a known opcode and after an unknown one, to show the interrupt test depends on both inputs and happens only at the end of execute. A reset in the middle of an execute part shows that reset returns the block to fetch step 0 from any state.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    // Field order puts pc2mar at bit 0 and ira2pc at the top bit.
    typedef struct packed {
        logic ira2pc;
        logic mbr_inc;
        logic mbr2ira;
        logic vec2pc;
        logic save2mar;
        logic pc2mbr;
        logic alu_add;
        logic mbr2mem;
        logic ira2mar;
        logic pc_inc;
        logic mbr2ir;
        logic mem2mbr;
        logic pc2mar;
    } strobe_s;

    localparam int STROBE_W  = $bits(strobe_s);
    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    function automatic phase_e next_phase(phase_e cur, logic ind, logic irq, logic en);
        case (cur)
            PH_FETCH: return ind ? PH_INDIR : PH_EXEC;
            PH_INDIR: return PH_EXEC;
            PH_EXEC:  return (irq && en) ? PH_INTR : PH_FETCH;
            default:  return PH_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/ctl_step_timer.sv
module ctl_step_timer
    import ctl_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    output logic [STEP_W-1:0] step
);

    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || wrap) step_q <= '0;
        else             step_q <= step_q + 1'b1;
    end

    assign step = step_q;

    p_step_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (step == '0));

endmodule

// File: rtl/ctl_phase_fsm.sv
module ctl_phase_fsm
    import ctl_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   at_end,
    input  logic   ind_bit,
    input  logic   irq,
    input  logic   irq_en,
    output phase_e phase
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= PH_FETCH;
        else if (at_end) phase_q <= next_phase(phase_q, ind_bit, irq, irq_en);
    end

    assign phase = phase_q;

    p_fetch_branch_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && at_end) |=>
            (phase == ($past(ind_bit) ? PH_INDIR : PH_EXEC)));

    p_indir_exec_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INDIR && at_end) |=> (phase == PH_EXEC));

    p_intr_return_r11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INTR && at_end) |=> (phase == PH_FETCH));

endmodule

// File: rtl/ctl_strobe_decode.sv
module ctl_strobe_decode
    import ctl_seq_pkg::*;
#(
    parameter int               OPC_W   = 4,
    parameter logic [OPC_W-1:0] OPC_ADD = OPC_W'(1),
    parameter logic [OPC_W-1:0] OPC_ISZ = OPC_W'(2),
    parameter logic [OPC_W-1:0] OPC_BSA = OPC_W'(3)
) (
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              zero_flag,
    output strobe_s           strb,
    output logic              at_end
);

    localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
    localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
    localparam logic [STEP_W-1:0] S3 = STEP_W'(3);

    logic [STEP_W-1:0] last;

    always_comb begin
        strb = '0;
        last = S2;
        case (phase)
            PH_FETCH: begin
                strb.pc2mar  = (step == S0);
                strb.mem2mbr = (step == S1);
                strb.pc_inc  = (step == S1);
                strb.mbr2ir  = (step == S2);
            end
            PH_INDIR: begin
                strb.ira2mar = (step == S0);
                strb.mem2mbr = (step == S1);
                strb.mbr2ira = (step == S2);
            end
            PH_EXEC: begin
                if (opcode == OPC_ADD) begin
                    strb.ira2mar = (step == S0);
                    strb.mem2mbr = (step == S1);
                    strb.alu_add = (step == S2);
                end else if (opcode == OPC_ISZ) begin
                    last         = S3;
                    strb.ira2mar = (step == S0);
                    strb.mem2mbr = (step == S1);
                    strb.mbr_inc = (step == S2);
                    strb.mbr2mem = (step == S3);
                    strb.pc_inc  = (step == S3) && zero_flag;
                end else if (opcode == OPC_BSA) begin
                    strb.ira2mar = (step == S0);
                    strb.pc2mbr  = (step == S0);
                    strb.ira2pc  = (step == S1);
                    strb.mbr2mem = (step == S1);
                    strb.pc_inc  = (step == S2);
                end else begin
                    last = S0;
                end
            end
            default: begin
                strb.pc2mbr   = (step == S0);
                strb.save2mar = (step == S1);
                strb.vec2pc   = (step == S1);
                strb.mbr2mem  = (step == S2);
            end
        endcase
        at_end = (step >= last);
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import ctl_seq_pkg::*;
#(
    parameter int               OPC_W   = 4,
    parameter logic [OPC_W-1:0] OPC_ADD = OPC_W'(1),
    parameter logic [OPC_W-1:0] OPC_ISZ = OPC_W'(2),
    parameter logic [OPC_W-1:0] OPC_BSA = OPC_W'(3)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OPC_W-1:0]    opcode,
    input  logic                ind_bit,
    input  logic                zero_flag,
    input  logic                irq,
    input  logic                irq_en,
    output logic [1:0]          cycle_code,
    output logic [STEP_W-1:0]   step,
    output logic [STROBE_W-1:0] ctl
);

    phase_e            phase;
    logic [STEP_W-1:0] step_w;
    strobe_s           strb;
    logic              at_end;

    ctl_step_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .wrap (at_end),
        .step (step_w)
    );

    ctl_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .at_end  (at_end),
        .ind_bit (ind_bit),
        .irq     (irq),
        .irq_en  (irq_en),
        .phase   (phase)
    );

    ctl_strobe_decode #(
        .OPC_W   (OPC_W),
        .OPC_ADD (OPC_ADD),
        .OPC_ISZ (OPC_ISZ),
        .OPC_BSA (OPC_BSA)
    ) u_dec (
        .phase     (phase),
        .step      (step_w),
        .opcode    (opcode),
        .zero_flag (zero_flag),
        .strb      (strb),
        .at_end    (at_end)
    );

    assign cycle_code = phase;
    assign step       = step_w;
    assign ctl        = strb;

    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (cycle_code == 2'b00 && step == '0));

    p_step_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (cycle_code != $past(cycle_code)) |-> (step == '0));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (cycle_code == 2'b11 && $past(cycle_code) == 2'b10) |-> $past(irq && irq_en));

    p_step3_isz_r7: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_W'(3)) |-> (cycle_code == 2'b10 && opcode == OPC_ISZ));

    p_mbr_rw_r12: assert property (@(posedge clk) disable iff (rst)
        ctl[1] |-> !(ctl[2] || ctl[5] || ctl[10] || ctl[11]));

endmodule

// File: tb/test_ctl_sequencer.sv
module test_ctl_sequencer;

    localparam int W = 13;
    localparam logic [W-1:0] B_PC2MAR = 13'h0001, B_RD = 13'h0002, B_IR = 13'h0004,
        B_PCI = 13'h0008, B_IRA = 13'h0010, B_WR = 13'h0020, B_ADD = 13'h0040,
        B_PC2MBR = 13'h0080, B_SAVE = 13'h0100, B_VEC = 13'h0200, B_MBRA = 13'h0400,
        B_INC = 13'h0800, B_IRA2PC = 13'h1000;

    typedef struct {
        logic [1:0]   ph;
        logic [1:0]   st;
        logic [W-1:0] m;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic ind_bit = 1'b0, zero_flag = 1'b0, irq = 1'b0, irq_en = 1'b0;
    logic [1:0] cycle_code;
    logic [1:0] step;
    logic [W-1:0] ctl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ctl_sequencer i_ctl_sequencer (
        .clk(clk), .rst(rst), .opcode(opcode), .ind_bit(ind_bit),
        .zero_flag(zero_flag), .irq(irq), .irq_en(irq_en),
        .cycle_code(cycle_code), .step(step), .ctl(ctl)
    );

    task automatic push(input logic [1:0] ph, input logic [1:0] st,
                        input logic [W-1:0] m, input string tag);
        exp_t e;
        e.ph = ph; e.st = st; e.m = m; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one expected item per cycle, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (cycle_code !== e.ph || step !== e.st || ctl !== e.m) begin
                    n_fail++;
                    $display("FAIL %s: got code=%b step=%0d ctl=%h, expected code=%b step=%0d ctl=%h",
                             e.tag, cycle_code, step, ctl, e.ph, e.st, e.m);
                end
            end
        end
    end

    // Called just after a rising edge with the design in fetch step 0.
    task automatic run_instr(input logic [3:0] op, input logic ind, input logic z,
                             input logic rq, input logic en);
        int n = 0;
        opcode = op; ind_bit = ind; zero_flag = z; irq = rq; irq_en = en;
        push(2'b00, 2'd0, B_PC2MAR, "R3");
        push(2'b00, 2'd1, B_RD | B_PCI, "R3");
        push(2'b00, 2'd2, B_IR, "R3");
        n += 3;
        if (ind) begin
            push(2'b01, 2'd0, B_IRA, "R4");   // R4: indirect taken
            push(2'b01, 2'd1, B_RD, "R5");
            push(2'b01, 2'd2, B_MBRA, "R5");
            n += 3;
        end
        case (op)
            4'h1: begin   // R6
                push(2'b10, 2'd0, B_IRA, ind ? "R5" : "R4");
                push(2'b10, 2'd1, B_RD, "R6");
                push(2'b10, 2'd2, B_ADD, "R6");
                n += 3;
            end
            4'h2: begin   // R7
                push(2'b10, 2'd0, B_IRA, "R7");
                push(2'b10, 2'd1, B_RD, "R7");
                push(2'b10, 2'd2, B_INC, "R7");
                push(2'b10, 2'd3, B_WR | (z ? B_PCI : '0), "R7");
                n += 4;
            end
            4'h3: begin   // R8
                push(2'b10, 2'd0, B_IRA | B_PC2MBR, "R8");
                push(2'b10, 2'd1, B_IRA2PC | B_WR, "R8");
                push(2'b10, 2'd2, B_PCI, "R8");
                n += 3;
            end
            default: begin   // R9
                push(2'b10, 2'd0, '0, "R9");
                n += 1;
            end
        endcase
        if (rq && en) begin
            push(2'b11, 2'd0, B_PC2MBR, "R10");
            push(2'b11, 2'd1, B_SAVE | B_VEC, "R11");
            push(2'b11, 2'd2, B_WR, "R11");
            n += 3;
        end
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R1: direct check that the design sits in fetch step 0 after reset.
    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        n_tests++;
        if (cycle_code !== 2'b00 || step !== 2'd0 || ctl !== B_PC2MAR) begin
            n_fail++;
            $display("FAIL R1: got code=%b step=%0d ctl=%h, expected code=00 step=0 ctl=%h",
                     cycle_code, step, ctl, B_PC2MAR);
        end
    endtask

    initial begin
        do_reset();
        run_instr(4'h1, 1'b0, 1'b0, 1'b0, 1'b0);   // R6 direct add
        run_instr(4'h1, 1'b1, 1'b1, 1'b0, 1'b1);   // R4 R5 indirect add
        run_instr(4'h2, 1'b0, 1'b0, 1'b0, 1'b0);   // R7 no skip
        run_instr(4'h2, 1'b0, 1'b1, 1'b0, 1'b0);   // R7 skip
        run_instr(4'h3, 1'b0, 1'b0, 1'b1, 1'b1);   // R8 then R10 R11 interrupt
        run_instr(4'hA, 1'b0, 1'b0, 1'b1, 1'b0);   // R9, R10 disabled request
        run_instr(4'hA, 1'b1, 1'b0, 1'b0, 1'b1);   // R9 indirect, no request
        run_instr(4'h2, 1'b1, 1'b1, 1'b1, 1'b1);   // R7 indirect then interrupt
        run_instr(4'h3, 1'b1, 1'b0, 1'b0, 1'b0);   // R8 indirect
        // R1: reset while in the middle of execute
        opcode = 4'h2; ind_bit = 1'b0; irq = 1'b0; irq_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        do_reset();
        run_instr(4'h1, 1'b0, 1'b0, 1'b1, 1'b1);   // R2 R10 after re-reset
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule